// File: doc/BRIEF.md
# Boundary Run-Test Operation Engine

This block runs built-in self-test on a boundary register while the test access port rests in Run-Test/Idle and the run-test instruction is active. The register holds a group of input cells, which face the device input pins, and a group of output cells, which feed the device output pins. A 3-bit operation code, held in a separately scanned control register, selects one of five operations. The operations are: sampling the pins while inverting the outputs, pseudo-random pattern generation on the output cells, signature compaction of the pins into the input cells, both of the last two at once, and compaction combined with a binary up-count on the outputs.

The test clock is modelled as a pair of one-cycle strobes in the system clock domain. The rising-edge strobe advances the cells by one step. The falling-edge strobe copies the output cells onto the output pins. A parallel load port stands for the update path of the surrounding scan logic. It seeds both groups of cells before a run. After a run, the input cells are left holding the signature, which can be read out later through the normal scan path.

Top module: `bist_run_engine`

## Requirements
- R1: After reset, in_cells, out_cells and pins_out are all zero.
- R2: The cells change only on a cycle where tck_rise, in_rti and run_instr are all 1, or where ld_en is 1. Otherwise both cell groups hold their values.
- R3: When ld_en is 1, in_cells takes ld_in and out_cells takes ld_out on the next clock. This load takes priority over any test step in the same cycle.
- R4: Op code 3'b000 (sample/toggle): on a step, in_cells takes pins_in and out_cells takes its bitwise inverse.
- R5: Op code 3'b001 (pattern generation): on a step, out_cells advances one LFSR step: shift left one place, and if the old MSB was 1, XOR with 8'h71 (polynomial x^8+x^6+x^5+x^4+1). An all-zero out_cells becomes 8'h01 instead. in_cells holds.
- R6: Op code 3'b010 (signature): on a step, in_cells takes the same LFSR step of itself XOR pins_in, with pin i entering stage i. out_cells holds.
- R7: Op code 3'b011: on a step, the R6 signature update and the R5 pattern update happen together.
- R8: Op code 3'b100: on a step, in_cells takes the R6 update and out_cells counts up by one, wrapping from all ones to zero.
- R9: Op codes 3'b101 to 3'b111 change neither cell group on a step.
- R10: pins_out takes the value of out_cells on the clock where tck_fall is 1. It holds at every other clock, including across a rising-edge step.
- R11: From any nonzero seed, pattern generation returns to that seed after exactly 255 steps, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tck_rise | input | 1 | One-cycle strobe for a rising test-clock edge |
| tck_fall | input | 1 | One-cycle strobe for a falling test-clock edge |
| in_rti | input | 1 | Controller is in Run-Test/Idle |
| run_instr | input | 1 | Run-test instruction is active |
| op_code | input | 3 | Operation selected by the control register |
| pins_in | input | N_CELLS | Device input pin values |
| ld_en | input | 1 | Parallel load of the cells from the scan update path |
| ld_in | input | N_CELLS | Load value for the input cells |
| ld_out | input | N_CELLS | Load value for the output cells |
| in_cells | output | N_CELLS | Input cell contents (signature) |
| out_cells | output | N_CELLS | Output cell contents |
| pins_out | output | N_CELLS | Values driven on the device output pins |

## Verification
The hardest state to reach from the ports is the full pattern cycle. Confirming that the generator is maximal-length takes 255 back-to-back steps with no early return to the seed. The bench loads a seed through the load port, steps continuously, and tracks the first repeat. The remaining corners are an all-zero pattern seed and an all-ones counter. The load port puts each of these in place directly, so neither has to be reached by a long walk.

// File: rtl/bre_pkg.sv
package bre_pkg;

    typedef enum logic [2:0] {
        OP_SAMPLE_TOGGLE = 3'b000,
        OP_PATTERN       = 3'b001,
        OP_SIGNATURE     = 3'b010,
        OP_SIG_PATTERN   = 3'b011,
        OP_SIG_COUNT     = 3'b100
    } run_op_e;

    typedef struct packed {
        logic load_pins;
        logic invert_out;
        logic pattern_out;
        logic sig_in;
        logic count_out;
    } op_flags_t;

endpackage

// File: rtl/bre_op_decode.sv
module bre_op_decode
    import bre_pkg::*;
(
    input  logic [2:0] op_code,
    output op_flags_t  flags
);
    always_comb begin
        flags = '0;
        case (op_code)
            OP_SAMPLE_TOGGLE: begin
                flags.load_pins  = 1'b1;
                flags.invert_out = 1'b1;
            end
            OP_PATTERN:       flags.pattern_out = 1'b1;
            OP_SIGNATURE:     flags.sig_in      = 1'b1;
            OP_SIG_PATTERN: begin
                flags.sig_in      = 1'b1;
                flags.pattern_out = 1'b1;
            end
            OP_SIG_COUNT: begin
                flags.sig_in    = 1'b1;
                flags.count_out = 1'b1;
            end
            default:          flags = '0;
        endcase
    end
endmodule

// File: rtl/bre_lfsr_step.sv
module bre_lfsr_step #(
    parameter int            W    = 8,
    parameter logic [W-1:0]  TAPS = 8'h71
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] inj,
    output logic [W-1:0] nxt
);
    logic fb;
    assign fb = cur[W-1];

    for (genvar i = 0; i < W; i++) begin : g_stage
        if (i == 0) begin : g_first
            assign nxt[i] = (fb & TAPS[i]) ^ inj[i];
        end else begin : g_rest
            assign nxt[i] = cur[i-1] ^ (fb & TAPS[i]) ^ inj[i];
        end
    end
endmodule

// File: rtl/bist_run_engine.sv
module bist_run_engine
    import bre_pkg::*;
#(
    parameter int                 N_CELLS = 8,
    parameter logic [N_CELLS-1:0] POLY    = 8'h71
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               tck_rise,
    input  logic               tck_fall,
    input  logic               in_rti,
    input  logic               run_instr,
    input  logic [2:0]         op_code,
    input  logic [N_CELLS-1:0] pins_in,
    input  logic               ld_en,
    input  logic [N_CELLS-1:0] ld_in,
    input  logic [N_CELLS-1:0] ld_out,
    output logic [N_CELLS-1:0] in_cells,
    output logic [N_CELLS-1:0] out_cells,
    output logic [N_CELLS-1:0] pins_out
);
    localparam logic [N_CELLS-1:0] SEED_ONE = N_CELLS'(1);

    typedef struct packed {
        logic [N_CELLS-1:0] in_c;
        logic [N_CELLS-1:0] out_c;
        logic [N_CELLS-1:0] pins;
    } state_t;

    state_t    st_d, st_q;
    op_flags_t flags;
    logic      step;
    logic [N_CELLS-1:0] sig_next, pat_next;

    bre_op_decode i_dec (
        .op_code (op_code),
        .flags   (flags)
    );

    bre_lfsr_step #(.W(N_CELLS), .TAPS(POLY)) i_sig (
        .cur (st_q.in_c),
        .inj (pins_in),
        .nxt (sig_next)
    );

    bre_lfsr_step #(.W(N_CELLS), .TAPS(POLY)) i_pat (
        .cur (st_q.out_c),
        .inj ('0),
        .nxt (pat_next)
    );

    assign step = tck_rise & in_rti & run_instr;

    always_comb begin
        st_d = st_q;
        if (ld_en) begin
            st_d.in_c  = ld_in;
            st_d.out_c = ld_out;
        end else if (step) begin
            if (flags.load_pins)  st_d.in_c = pins_in;
            if (flags.sig_in)     st_d.in_c = sig_next;
            if (flags.invert_out) st_d.out_c = ~st_q.out_c;
            if (flags.pattern_out)
                st_d.out_c = (st_q.out_c == '0) ? SEED_ONE : pat_next;
            if (flags.count_out)  st_d.out_c = st_q.out_c + SEED_ONE;
        end
        if (tck_fall) st_d.pins = st_q.out_c;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign in_cells  = st_q.in_c;
    assign out_cells = st_q.out_c;
    assign pins_out  = st_q.pins;

    assert_hold_when_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && !step) |=> ($stable(in_cells) && $stable(out_cells)));

    assert_load_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (in_cells == $past(ld_in) && out_cells == $past(ld_out)));

    assert_toggle_inverts_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_en && op_code == OP_SAMPLE_TOGGLE)
        |=> (out_cells == ~$past(out_cells) && in_cells == $past(pins_in)));

    assert_pattern_nonzero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_en && op_code == OP_PATTERN)
        |=> (out_cells != '0 && $stable(in_cells)));

    assert_count_up_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_en && op_code == OP_SIG_COUNT)
        |=> (out_cells == $past(out_cells) + SEED_ONE));

    assert_reserved_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !ld_en && op_code > 3'b100)
        |=> ($stable(in_cells) && $stable(out_cells)));

    assert_pins_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        tck_fall |=> (pins_out == $past(out_cells)));

    assert_pins_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !tck_fall |=> $stable(pins_out));
endmodule

// File: tb/test_bist_run_engine.sv
module test_bist_run_engine;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tck_rise = 1'b0, tck_fall = 1'b0;
    logic       in_rti = 1'b0, run_instr = 1'b0;
    logic [2:0] op_code = 3'b000;
    logic [7:0] pins_in = '0;
    logic       ld_en = 1'b0;
    logic [7:0] ld_in = '0, ld_out = '0;
    logic [7:0] in_cells, out_cells, pins_out;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    bist_run_engine i_bist_run_engine (
        .clk, .rst_n, .tck_rise, .tck_fall, .in_rti, .run_instr, .op_code,
        .pins_in, .ld_en, .ld_in, .ld_out, .in_cells, .out_cells, .pins_out
    );

    function automatic logic [7:0] lstep(input logic [7:0] c, input logic [7:0] inj);
        return ({c[6:0], 1'b0} ^ (c[7] ? 8'h71 : 8'h00)) ^ inj;
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic load(input logic [7:0] vi, input logic [7:0] vo);
        ld_in = vi; ld_out = vo; ld_en = 1'b1;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic rise();
        tck_rise = 1'b1;
        @(negedge clk);
        tck_rise = 1'b0;
    endtask

    task automatic fall();
        tck_fall = 1'b1;
        @(negedge clk);
        tck_fall = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 in", in_cells, 8'h00);
        check("R1 out", out_cells, 8'h00);
        check("R1 pins", pins_out, 8'h00);
    endtask

    task automatic t_load();
        in_rti = 1'b1; run_instr = 1'b1; op_code = 3'b000;
        ld_in = 8'h3C; ld_out = 8'hA5; ld_en = 1'b1; tck_rise = 1'b1;
        @(negedge clk);
        ld_en = 1'b0; tck_rise = 1'b0;
        check("R3 in", in_cells, 8'h3C);
        check("R3 out", out_cells, 8'hA5);
    endtask

    task automatic t_hold();
        load(8'h12, 8'h34);
        op_code = 3'b000; pins_in = 8'hFF;
        in_rti = 1'b0; run_instr = 1'b1; rise();
        check("R2 no rti in", in_cells, 8'h12);
        check("R2 no rti out", out_cells, 8'h34);
        in_rti = 1'b1; run_instr = 1'b0; rise();
        check("R2 no instr out", out_cells, 8'h34);
        run_instr = 1'b1;
        @(negedge clk);
        check("R2 no strobe out", out_cells, 8'h34);
    endtask

    task automatic t_toggle();
        load(8'h00, 8'h5A);
        op_code = 3'b000; pins_in = 8'hC3; rise();
        check("R4 in", in_cells, 8'hC3);
        check("R4 out", out_cells, 8'hA5);
        pins_in = 8'h18; rise();
        check("R4 in2", in_cells, 8'h18);
        check("R4 out2", out_cells, 8'h5A);
    endtask

    task automatic t_pattern();
        logic [7:0] e;
        load(8'h77, 8'h00);
        op_code = 3'b001; rise();
        check("R5 zero seed", out_cells, 8'h01);
        check("R5 in hold", in_cells, 8'h77);
        load(8'h77, 8'h80);
        e = lstep(8'h80, 8'h00);
        rise();
        check("R5 msb feedback", out_cells, e);
        e = lstep(e, 8'h00);
        rise();
        check("R5 second step", out_cells, e);
    endtask

    task automatic t_period();
        int first = 0;
        load(8'h00, 8'h9D);
        op_code = 3'b001;
        tck_rise = 1'b1;
        for (int k = 1; k <= 255; k++) begin
            @(negedge clk);
            if (out_cells == 8'h9D && first == 0) first = k;
        end
        tck_rise = 1'b0;
        check("R11 period", 8'(first), 8'(255));
    endtask

    task automatic t_signature();
        logic [7:0] s;
        load(8'h81, 8'h66);
        op_code = 3'b010; s = 8'h81;
        pins_in = 8'h0F; rise(); s = lstep(s, 8'h0F);
        check("R6 sig1", in_cells, s);
        pins_in = 8'hF0; rise(); s = lstep(s, 8'hF0);
        check("R6 sig2", in_cells, s);
        check("R6 out hold", out_cells, 8'h66);
    endtask

    task automatic t_both();
        load(8'h2B, 8'hC4);
        op_code = 3'b011; pins_in = 8'h55; rise();
        check("R7 in", in_cells, lstep(8'h2B, 8'h55));
        check("R7 out", out_cells, lstep(8'hC4, 8'h00));
    endtask

    task automatic t_count();
        load(8'hE0, 8'hFE);
        op_code = 3'b100; pins_in = 8'h01; rise();
        check("R8 count", out_cells, 8'hFF);
        check("R8 sig", in_cells, lstep(8'hE0, 8'h01));
        rise();
        check("R8 wrap", out_cells, 8'h00);
    endtask

    task automatic t_reserved();
        for (int c = 5; c < 8; c++) begin
            load(8'h4E, 8'hB1);
            op_code = 3'(c); pins_in = 8'hFF; rise();
            check("R9 in", in_cells, 8'h4E);
            check("R9 out", out_cells, 8'hB1);
        end
    endtask

    task automatic t_pins();
        load(8'h00, 8'h3A);
        fall();
        check("R10 fall", pins_out, 8'h3A);
        op_code = 3'b000; rise();
        check("R10 hold on rise", pins_out, 8'h3A);
        fall();
        check("R10 after fall", pins_out, 8'hC5);
    endtask

    initial begin
        #100000;
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (2) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load();
        t_hold();
        t_toggle();
        t_pattern();
        t_period();
        t_signature();
        t_both();
        t_count();
        t_reserved();
        t_pins();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule